// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block gathers a large set of raw interrupt lines, arranged in groups of eight, and turns them into one request line to a processor plus a vector number naming the source that should be served first. Each line passes a two-flop synchroniser. It can then be configured as level or edge sensitive, with either sense of polarity. A detected event latches a pending bit that software clears by writing a one.

Software reaches the block over a byte-wide register bus. Every group owns four byte registers: pending, enable, sensing mode and polarity. A separate vector register reports the winning source. The processor reads the vector and clears the pending bit of the source it serves. It then reads the vector again until no enabled source is pending.

Top module: `irqgrp_ctrl`

## Requirements
- R1: Group g has its four registers at byte offset 4*g (g below 4) or 4*g+4 (g of 4 and above). The register order is pending (+0), enable (+1), mode (+2) and polarity (+3). Source n is bit n%8 of group n/8. The vector register sits at offset 0x70. A read returns its value on `bus_rdata` after the clock edge on which `bus_rd` was high.
- R2: After reset every pending, enable, mode and polarity bit is 0. The enable, mode and polarity registers read back the value last written.
- R3: Writing a 1 to a bit of a pending register clears that bit on that clock edge, and a clear wins over a new event on the same edge. Writing a 0 leaves the bit unchanged.
- R4: With mode bit 0 (level), a source is pending on every edge at which its synchronised input is at the active level. Polarity 0 makes high active and polarity 1 makes low active. While the input stays active, the bit sets again on the edge after a clear.
- R5: With mode bit 1 (edge), a pending bit sets only on a synchronised transition. Polarity 0 selects a low-to-high transition and polarity 1 a high-to-low one. A held input or a transition of the other direction sets nothing.
- R6: `irq_vector` and the vector register read 0x10 plus the number of the selected source. They read exactly 0x10 when no enabled source is pending, and also when source 0 wins. `irq_req` tells these two cases apart.
- R7: Among sources that are both pending and enabled, the one with the highest number wins. This means the highest group first, then the most significant bit inside that group.
- R8: `irq_req` is high exactly when some source is both pending and enabled. A pending source whose enable bit is 0 is visible in its pending register but raises no request.
- R9: Reads of offsets outside the map return 0, and writes to them change no register.
- R10: A change on a raw input sets a pending bit on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_GROUPS*8 | Raw interrupt lines, bit n is source n |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data follows on the next cycle |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Request to the processor |
| irq_vector | output | 8 | 0x10 plus the winning source number |

## Verification
The bench exercises level sensing in both polarities, and checks that a held level reasserts after a clear where a held edge does not. It drives edges of each direction under each polarity, so a detector that ignores the polarity bit or fires on both directions is caught. Priority is tried between adjacent groups and inside one group, with and without enables, to separate group ordering from bit ordering and pending state from the request. The register map is probed on both sides of the gap between group 3 and group 4, which exposes a decoder that ignores the irregular offset. A behavioural reference model follows every clock and compares the request, the vector and the read data.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;
    localparam int GW = 8;
    localparam logic [7:0] VEC_BASE = 8'h10;

    typedef struct packed {
        logic [GW-1:0] stat;
        logic [GW-1:0] en;
        logic [GW-1:0] mode;
        logic [GW-1:0] pol;
        logic [GW-1:0] prev;
    } bank_regs_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_MODE,
        SEL_POL
    } bank_sel_e;
endpackage

// File: rtl/irqgrp_sync.sv
module irqgrp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/irqgrp_bank.sv
module irqgrp_bank
    import irqgrp_pkg::*;
#(
    parameter int GID = 0,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] irq_in,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_wr,
    output logic [GW-1:0] take,
    output logic [7:0]    rd_val
);
    localparam int BASE = 4 * GID + ((GID < 4) ? 0 : 4);

    logic [GW-1:0] lvl_s;
    bank_regs_t    r_d, r_q;
    bank_sel_e     sel;
    logic [GW-1:0] active, rise, fall, edge_hit, set_v, clr_v;

    irqgrp_sync #(.W(GW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (lvl_s)
    );

    always_comb begin
        if (int'(bus_addr) == BASE)          sel = SEL_STAT;
        else if (int'(bus_addr) == BASE + 1) sel = SEL_EN;
        else if (int'(bus_addr) == BASE + 2) sel = SEL_MODE;
        else if (int'(bus_addr) == BASE + 3) sel = SEL_POL;
        else                                 sel = SEL_NONE;
    end

    always_comb begin
        active   = lvl_s ^ r_q.pol;
        rise     = lvl_s & ~r_q.prev;
        fall     = ~lvl_s & r_q.prev;
        edge_hit = (rise & ~r_q.pol) | (fall & r_q.pol);
        set_v    = (edge_hit & r_q.mode) | (active & ~r_q.mode);
        clr_v    = (bus_wr && sel == SEL_STAT) ? bus_wdata : '0;

        r_d      = r_q;
        r_d.prev = lvl_s;
        r_d.stat = (r_q.stat | set_v) & ~clr_v;
        if (bus_wr) begin
            case (sel)
                SEL_EN:   r_d.en   = bus_wdata;
                SEL_MODE: r_d.mode = bus_wdata;
                SEL_POL:  r_d.pol  = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        take = r_q.stat & r_q.en;
        case (sel)
            SEL_STAT: rd_val = r_q.stat;
            SEL_EN:   rd_val = r_q.en;
            SEL_MODE: rd_val = r_q.mode;
            SEL_POL:  rd_val = r_q.pol;
            default:  rd_val = '0;
        endcase
    end

    // R3: a written one leaves its pending bit clear after the edge
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_STAT) |=> ((r_q.stat & $past(bus_wdata)) == '0));

    // R4: an active level-mode input is pending after any edge without a clear
    assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel == SEL_STAT) |=>
            (($past((lvl_s ^ r_q.pol) & ~r_q.mode) & ~r_q.stat) == '0));

    // R5: a new edge-mode pending bit needs a change of the synchronised input
    assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((r_q.stat & ~$past(r_q.stat) & $past(r_q.mode)
                    & ~$past(lvl_s ^ r_q.prev)) == '0));
endmodule

// File: rtl/irqgrp_pick.sv
module irqgrp_pick #(
    parameter int N  = 192,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqgrp_ctrl.sv
module irqgrp_ctrl
    import irqgrp_pkg::*;
#(
    parameter int NUM_GROUPS = 24,
    parameter int AW         = 8,
    parameter int VEC_OFS    = 112
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GROUPS*GW-1:0] irq_src,
    input  logic [AW-1:0]            bus_addr,
    input  logic [7:0]               bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [7:0]               bus_rdata,
    output logic                     irq_req,
    output logic [7:0]               irq_vector
);
    localparam int NSRC = NUM_GROUPS * GW;
    localparam int IW   = $clog2(NSRC);

    logic [NSRC-1:0] take_all;
    logic [7:0]      bank_rd [NUM_GROUPS];
    logic [IW-1:0]   win;
    logic            any;
    logic [7:0]      rd_mux;
    logic [7:0]      rdata_d, rdata_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        irqgrp_bank #(.GID(g), .AW(AW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_in    (irq_src[g*GW +: GW]),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .bus_wr    (bus_wr),
            .take      (take_all[g*GW +: GW]),
            .rd_val    (bank_rd[g])
        );
    end

    irqgrp_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req (take_all),
        .any (any),
        .idx (win)
    );

    always_comb begin
        irq_req    = any;
        irq_vector = any ? (VEC_BASE + 8'(win)) : VEC_BASE;
    end

    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_GROUPS; g++) rd_mux = rd_mux | bank_rd[g];
        if (int'(bus_addr) == VEC_OFS) rd_mux = irq_vector;
        rdata_d = bus_rd ? rd_mux : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R8: a vector above the base always comes with a request
    assert_vector_has_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vector != VEC_BASE) |-> irq_req);

    // R6: with a request the vector names a real source
    assert_vector_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector >= VEC_BASE && irq_vector <= VEC_BASE + 8'(NSRC - 1)));
endmodule

// File: tb/irqgrp_ctrl_tb.sv
module irqgrp_ctrl_tb;
    localparam int NG = 24;
    localparam int NS = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src;
    logic [7:0]    addr, wdata;
    logic          wr, rd;
    logic [7:0]    bus_rdata, irq_vector;
    logic          irq_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqgrp_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src    (src),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_wr     (wr),
        .bus_rd     (rd),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // behavioural reference model
    logic [NS-1:0] ms1, ms2, mprev, mstat, men, mmode, mpol, nstat;
    logic [7:0]    mrd;
    int  dg, dk;
    bit  t_act, t_edge, t_set, t_clr;

    function automatic void decode(input int a, output int g, output int k);
        g = -1;
        k = -1;
        for (int i = 0; i < NG; i++) begin
            int b;
            b = (i < 4) ? 4 * i : 4 * i + 4;
            if (a >= b && a < b + 4) begin
                g = i;
                k = a - b;
            end
        end
    endfunction

    function automatic int mvec();
        for (int n = NS - 1; n >= 0; n--)
            if (mstat[n] && men[n]) return 16 + n;
        return 16;
    endfunction

    function automatic int mreq();
        return ((mstat & men) != '0) ? 1 : 0;
    endfunction

    function automatic logic [7:0] mread(input int a);
        int g, k;
        if (a == 112) return 8'(mvec());
        decode(a, g, k);
        case (k)
            0: return mstat[g*8 +: 8];
            1: return men[g*8 +: 8];
            2: return mmode[g*8 +: 8];
            3: return mpol[g*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms1 <= '0; ms2 <= '0; mprev <= '0; mstat <= '0;
            men <= '0; mmode <= '0; mpol <= '0; mrd <= '0;
        end else begin
            decode(int'(addr), dg, dk);
            for (int n = 0; n < NS; n++) begin
                t_act  = ms2[n] ^ mpol[n];
                t_edge = mpol[n] ? (mprev[n] && !ms2[n]) : (ms2[n] && !mprev[n]);
                t_set  = mmode[n] ? t_edge : t_act;
                t_clr  = wr && dk == 0 && dg == n / 8 && wdata[n % 8];
                nstat[n] = t_clr ? 1'b0 : (mstat[n] | t_set);
            end
            if (rd) mrd <= mread(int'(addr));
            mstat <= nstat;
            ms1   <= src;
            ms2   <= ms1;
            mprev <= ms2;
            if (wr && dk == 1) men[dg*8 +: 8]   <= wdata;
            if (wr && dk == 2) mmode[dg*8 +: 8] <= wdata;
            if (wr && dk == 3) mpol[dg*8 +: 8]  <= wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R8 request vs model", int'(irq_req), mreq());
            chk("R6/R7 vector vs model", int'(irq_vector), mvec());
            chk("R1/R9 read data vs model", int'(bus_rdata), int'(mrd));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic bwr(input int a, input int d);
        addr = 8'(a); wdata = 8'(d); wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input int a, output int d);
        addr = 8'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    initial begin
        int v;
        rst_n = 1'b0; src = '0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset request", int'(irq_req), 0);
        chk("R6 idle vector", int'(irq_vector), 'h10);
        brd(21, v); chk("R2 enable reset value", v, 0);

        // address map on both sides of the gap
        bwr(9, 'hA5);  brd(9, v);  chk("R1 group2 enable", v, 'hA5);
        bwr(21, 'h3C); brd(21, v); chk("R1 group4 enable at +4", v, 'h3C);
        bwr(26, 'h81); brd(26, v); chk("R2 mode readback", v, 'h81);
        brd(17, v); chk("R9 unmapped read", v, 0);
        bwr(17, 'hFF); brd(17, v); chk("R9 unmapped read after write", v, 0);
        brd(21, v); chk("R9 neighbour unchanged", v, 'h3C);
        bwr(9, 0); bwr(21, 0); bwr(26, 0);

        // level, active high, latency
        bwr(5, 'h04);
        src[10] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 not yet pending", int'(irq_req), 0);
        @(negedge clk);
        chk("R10 pending on third edge", int'(irq_req), 1);
        chk("R4 level vector", int'(irq_vector), 'h1A);
        brd(4, v); chk("R4 pending register", v, 'h04);
        bwr(4, 'h04);
        chk("R3 clear takes effect", int'(irq_vector), 'h10);
        @(negedge clk);
        chk("R4 level sets again", int'(irq_vector), 'h1A);
        src[10] = 1'b0;
        repeat (3) @(negedge clk);
        bwr(4, 'h04);
        chk("R3 cleared after release", int'(irq_req), 0);
        repeat (2) @(negedge clk);
        chk("R4 inactive level stays clear", int'(irq_req), 0);
        bwr(5, 0);

        // level, active low
        bwr(3, 'h08); bwr(1, 'h08);
        repeat (2) @(negedge clk);
        chk("R4 active low pending", int'(irq_vector), 'h13);
        src[3] = 1'b1;
        repeat (3) @(negedge clk);
        bwr(0, 'h08);
        chk("R4 high input inactive with polarity 1", int'(irq_req), 0);
        bwr(1, 0);
        src[3] = 1'b0;
        bwr(3, 0);
        repeat (3) @(negedge clk);
        bwr(0, 'hFF);

        // edge mode, group 5 at offset 24
        bwr(26, 'h01); bwr(25, 'h01);
        src[40] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 rising edge", int'(irq_vector), 'h38);
        bwr(24, 'h00);
        chk("R3 write of zero keeps pending", int'(irq_vector), 'h38);
        bwr(24, 'h01);
        repeat (3) @(negedge clk);
        chk("R5 held input no re-set", int'(irq_req), 0);
        src[40] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 falling ignored with polarity 0", int'(irq_req), 0);
        bwr(27, 'h01);
        src[40] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 rising ignored with polarity 1", int'(irq_req), 0);
        src[40] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 falling edge", int'(irq_vector), 'h38);
        bwr(24, 'h01); bwr(26, 0); bwr(27, 0); bwr(25, 0);

        // priority, groups 22 and 23
        bwr(97, 'h01); bwr(93, 'h80);
        src[183] = 1'b1; src[184] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 higher group wins", int'(irq_vector), 'hC8);
        bwr(97, 'h81);
        src[191] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 msb inside group", int'(irq_vector), 'hCF);
        brd(112, v); chk("R6 vector register read", v, 'hCF);
        bwr(97, 0);
        chk("R7 next group after disable", int'(irq_vector), 'hC7);
        bwr(93, 'h81);
        src[176] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 msb wins over lsb", int'(irq_vector), 'hC7);
        src[183] = 1'b0; src[184] = 1'b0; src[191] = 1'b0; src[176] = 1'b0;
        repeat (3) @(negedge clk);
        bwr(96, 'hFF); bwr(92, 'hFF); bwr(93, 0);

        // pending but disabled, group 12 at offset 52
        src[100] = 1'b1;
        repeat (3) @(negedge clk);
        brd(52, v); chk("R8 pending visible", v, 'h10);
        chk("R8 disabled raises nothing", int'(irq_req), 0);
        bwr(53, 'h10);
        chk("R8 enabled raises request", int'(irq_vector), 'h74);
        src[100] = 1'b0;
        repeat (3) @(negedge clk);
        bwr(52, 'h10); bwr(53, 0);

        // source 0
        bwr(1, 'h01);
        src[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 source 0 request", int'(irq_req), 1);
        chk("R6 source 0 vector", int'(irq_vector), 'h10);
        src[0] = 1'b0;
        repeat (3) @(negedge clk);
        bwr(0, 'h01); bwr(1, 0);
        chk("R8 idle at end", int'(irq_req), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule